// File: doc/BRIEF.md
# Wait/Hold Programmable Clock Divider

This block derives a domain clock from a source clock by an integer ratio. The ratio is made of two separate phase counts: a low-phase count and a high-phase count. The output stays low for (low count + 1) source cycles and then high for (high count + 1) source cycles, so the ratio is low + high + 2. To get a ratio R with an even or near-even duty cycle, software writes low = R/2 - 1 and high = R - low - 2. A bypass field routes the source clock straight to the output, and the counts then have no effect.

Software writes all fields through a single 32-bit register port. A write only changes the pending copy. The divider takes the new setting when the same write also sets the update-request bit. The hardware moves the pending copy into the active divider at the end of a complete output period, so no runt pulse appears. It clears the request bit in that same cycle, and software polls that bit to learn when the change is done. Leaving bypass counts as a period boundary on every cycle, so the new counts start on the next source cycle, beginning with the low phase. The parameter `CNT_W` sets the width of the count fields: 4 gives ratios from 2 to 32, and 3 gives ratios from 2 to 16.

Top module: `wh_clk_div`

## Requirements
- R1: After reset the register reads 0 (both counts 0, bypass clear, no request) and the output divides by 2: one low sample, then one high sample.
- R2: The low count is in bits [19:16], the high count in bits [23:20], bypass in bit 24 and the update request in bit 25. The pending values read back at these positions, and every other bit reads 0.
- R3: With bypass inactive, the output is low for (low+1) source cycles and then high for (high+1) source cycles. This covers ratio 2 (0/0) and ratio 32 (15/15) with 4-bit fields.
- R4: A write with bit 25 clear changes only the pending fields. The output period keeps its previous shape, and the request bit stays 0.
- R5: A requested setting takes effect only after the last high cycle of the current period. The request bit reads 1 until that boundary and reads 0 from the first cycle of the new setting. That cycle is at most (old ratio - 1) cycles after the write.
- R6: While bypass is active, the output equals the source clock and the counts have no effect.
- R7: When a committed setting clears bypass, the divider starts with the low phase on the next source cycle.
- R8: With CNT_W = 3, count bits above bit 2 of each field are dropped on write and read as 0. Writing 15/15 gives 8 low and 8 high cycles (ratio 16).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Source clock to be divided |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_wdata_i | input | REG_W | Register write data |
| cfg_rdata_o | output | REG_W | Register read data (pending fields and request bit) |
| clk_o | output | 1 | Divided or bypassed clock |

## Verification
On every cycle, the assertions check four things. The phase counter stays within the active count of its phase. The active setting changes only on a commit. Each commit restarts the divider in the low phase, and the counter stays idle in bypass. The request bit never rises without a write, and it clears at a commit. Some behaviour only the bench scenarios can show. These are the exact low/high lengths for several settings, including the extreme ratios. They also include the point in time when a request is committed relative to the old period, the ignored writes without the request bit, the bypass waveform at both clock levels, and the truncated fields of the narrow variant.

// File: rtl/wh_div_pkg.sv
package wh_div_pkg;
  localparam int FIELD_W  = 4;
  localparam int LO_LSB   = 16;
  localparam int HI_LSB   = 20;
  localparam int BYP_BIT  = 24;
  localparam int REQ_BIT  = 25;

  typedef struct packed {
    logic               byp;
    logic [FIELD_W-1:0] hi;
    logic [FIELD_W-1:0] lo;
  } div_cfg_t;
endpackage

// File: rtl/wh_div_regs.sv
module wh_div_regs
  import wh_div_pkg::*;
#(
  parameter int CNT_W = 4,
  parameter int REG_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [REG_W-1:0] wdata_i,
  input  logic             commit_i,
  output div_cfg_t         pend_o,
  output logic             req_o,
  output logic [REG_W-1:0] rdata_o
);
  localparam logic [FIELD_W-1:0] MASK = FIELD_W'((1 << CNT_W) - 1);

  div_cfg_t pend_q;
  logic     req_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
      req_q  <= 1'b0;
    end else if (we_i) begin
      pend_q.lo  <= wdata_i[LO_LSB +: FIELD_W] & MASK;
      pend_q.hi  <= wdata_i[HI_LSB +: FIELD_W] & MASK;
      pend_q.byp <= wdata_i[BYP_BIT];
      req_q      <= wdata_i[REQ_BIT];
    end else if (commit_i) begin
      req_q <= 1'b0;
    end
  end

  always_comb begin
    rdata_o                      = '0;
    rdata_o[LO_LSB +: FIELD_W]   = pend_q.lo;
    rdata_o[HI_LSB +: FIELD_W]   = pend_q.hi;
    rdata_o[BYP_BIT]             = pend_q.byp;
    rdata_o[REQ_BIT]             = req_q;
  end

  assign pend_o = pend_q;
  assign req_o  = req_q;

  AST_REQ_SELF_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_q && commit_i && !we_i) |=> !req_q); // R5
  AST_NO_SPURIOUS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!req_q && !we_i) |=> !req_q); // R4
  AST_FIELD_NARROW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> ((pend_q.lo & ~MASK) == '0) && ((pend_q.hi & ~MASK) == '0)); // R8
endmodule

// File: rtl/wh_div_core.sv
module wh_div_core
  import wh_div_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  div_cfg_t pend_i,
  input  logic     req_i,
  output logic     commit_o,
  output logic     byp_o,
  output logic     div_o
);
  div_cfg_t           act_q;
  logic               phase_q;   // 0: low phase, 1: high phase
  logic [FIELD_W-1:0] cnt_q;
  logic               boundary;

  // bypass counts as a boundary on every cycle
  assign boundary = act_q.byp | (phase_q & (cnt_q == act_q.hi));
  assign commit_o = boundary & req_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q   <= '0;
      phase_q <= 1'b0;
      cnt_q   <= '0;
    end else if (commit_o) begin
      act_q   <= pend_i;
      phase_q <= 1'b0;
      cnt_q   <= '0;
    end else if (act_q.byp) begin
      phase_q <= 1'b0;
      cnt_q   <= '0;
    end else if (!phase_q) begin
      if (cnt_q == act_q.lo) begin
        phase_q <= 1'b1;
        cnt_q   <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end else begin
      if (cnt_q == act_q.hi) begin
        phase_q <= 1'b0;
        cnt_q   <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign byp_o = act_q.byp;
  assign div_o = phase_q;

  AST_LOW_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!act_q.byp && !phase_q) |-> (cnt_q <= act_q.lo)); // R3
  AST_HIGH_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!act_q.byp && phase_q) |-> (cnt_q <= act_q.hi)); // R3
  AST_ACT_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !commit_o |=> (act_q == $past(act_q))); // R5
  AST_BYP_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_q.byp |-> (!phase_q && cnt_q == '0)); // R6
  AST_COMMIT_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_o |=> (!phase_q && cnt_q == '0)); // R7
endmodule

// File: rtl/wh_clk_div.sv
module wh_clk_div
  import wh_div_pkg::*;
#(
  parameter int CNT_W = 4,
  parameter int REG_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic [REG_W-1:0] cfg_wdata_i,
  output logic [REG_W-1:0] cfg_rdata_o,
  output logic             clk_o
);
  div_cfg_t pend;
  logic     req, commit, byp, div;

  wh_div_regs #(.CNT_W(CNT_W), .REG_W(REG_W)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (cfg_we_i),
    .wdata_i  (cfg_wdata_i),
    .commit_i (commit),
    .pend_o   (pend),
    .req_o    (req),
    .rdata_o  (cfg_rdata_o)
  );

  wh_div_core u_core (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .pend_i   (pend),
    .req_i    (req),
    .commit_o (commit),
    .byp_o    (byp),
    .div_o    (div)
  );

  assign clk_o = byp ? clk_i : div;

  initial begin
    AST_CNT_W_RANGE: assert (CNT_W >= 1 && CNT_W <= FIELD_W && REG_W > REQ_BIT); // R8
  end
endmodule

// File: tb/wh_clk_div_tb.sv
`timescale 1ns/1ps
module wh_clk_div_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_we = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] rdata, rdata_n;
  logic        clk_o, clk_n;

  int    n_tests = 0;
  int    n_fail  = 0;
  bit    done    = 0;
  logic  exp_q[$];
  string mon_tag = "R3";
  int    cur_ratio = 2;
  bit    cur_byp = 0;

  always #2.5 clk_i = ~clk_i;

  wh_clk_div u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .cfg_we_i(cfg_we), .cfg_wdata_i(cfg_wdata),
    .cfg_rdata_o(rdata), .clk_o(clk_o));

  wh_clk_div #(.CNT_W(3)) u_dut_n (
    .clk_i(clk_i), .rst_ni(rst_ni), .cfg_we_i(cfg_we), .cfg_wdata_i(cfg_wdata),
    .cfg_rdata_o(rdata_n), .clk_o(clk_n));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input int lo, input int hi, input bit byp, input bit upd);
    return (32'(upd) << 25) | (32'(byp) << 24) | (32'(hi) << 20) | (32'(lo) << 16);
  endfunction

  // monitor: pops one expected output level per cycle
  always @(posedge clk_i) begin
    #2;
    if (exp_q.size() > 0) begin
      logic e;
      e = exp_q.pop_front();
      chk(clk_o === e, mon_tag, int'(clk_o), int'(e));
    end
  end

  task automatic write_cfg(input logic [31:0] d);
    @(negedge clk_i);
    cfg_we = 1'b1;
    cfg_wdata = d;
    @(negedge clk_i);
    cfg_we = 1'b0;
    cfg_wdata = '0;
  endtask

  // driver: request a setting, find its first cycle, queue the expected waveform
  task automatic run_cfg(input int lo, input int hi, input bit byp, input int periods,
                         input logic [31:0] junk);
    logic prev;
    int   n;
    write_cfg(mk(lo, hi, byp, 1) | junk);
    chk(rdata[25] == 1'b1, "R5 request visible", int'(rdata[25]), 1);
    prev = cur_byp ? 1'b1 : clk_o;
    n = 0;
    forever begin
      @(posedge clk_i); #1;
      if (rdata[25] == 1'b0) break;
      prev = clk_o;
      n++;
    end
    chk(prev == 1'b1, "R5 commit after last high cycle", int'(prev), 1);
    chk(n < cur_ratio, "R5 commit within one old period", n, cur_ratio - 1);
    mon_tag = byp ? "R6" : (cur_byp ? "R7" : "R3");
    for (int p = 0; p < periods; p++) begin
      if (byp) exp_q.push_back(1'b1);
      else begin
        for (int i = 0; i <= lo; i++) exp_q.push_back(1'b0);
        for (int i = 0; i <= hi; i++) exp_q.push_back(1'b1);
      end
    end
    while (exp_q.size() > 0) @(posedge clk_i);
    #3;
    cur_byp = byp;
    cur_ratio = byp ? 1 : lo + hi + 2;
  endtask

  function automatic logic pick(input bit sel);
    return sel ? clk_n : clk_o;
  endfunction

  task automatic measure(input bit sel, output int lo, output int hi);
    logic s;
    lo = 0; hi = 0;
    do begin @(posedge clk_i); #1; s = pick(sel); end while (s != 1'b1);
    do begin @(posedge clk_i); #1; s = pick(sel); end while (s != 1'b0);
    while (s == 1'b0) begin lo++; @(posedge clk_i); #1; s = pick(sel); end
    while (s == 1'b1) begin hi++; @(posedge clk_i); #1; s = pick(sel); end
  endtask

  task automatic check_bypass_levels(input string tag);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk_i); #1;
      chk(clk_o == 1'b0, tag, int'(clk_o), 0);
      @(posedge clk_i); #1;
      chk(clk_o == 1'b1, tag, int'(clk_o), 1);
    end
  endtask

  initial begin
    #(200000 * 5);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual 0 expected 1");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int lo, hi;
    #12;
    // R1 reset state
    chk(rdata == 32'h0, "R1 reset register", int'(rdata), 0);
    chk(clk_o == 1'b0, "R1 reset output", int'(clk_o), 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    measure(0, lo, hi);
    chk(lo == 1, "R1 default low", lo, 1);
    chk(hi == 1, "R1 default high", hi, 1);

    // R3 3/4 with junk bits in unused positions (R2)
    run_cfg(3, 4, 0, 3, 32'h8000_0001);
    chk(rdata == 32'h0043_0000, "R2 field readback", int'(rdata), 32'h0043_0000);

    run_cfg(0, 0, 0, 4, 32'h0);   // R3 ratio 2
    run_cfg(15, 15, 0, 2, 32'h0); // R3 ratio 32
    // R8 narrow variant
    chk(rdata_n == 32'h0077_0000, "R8 narrow readback", int'(rdata_n), 32'h0077_0000);
    measure(1, lo, hi);
    chk(lo == 8, "R8 narrow low", lo, 8);
    chk(hi == 8, "R8 narrow high", hi, 8);

    run_cfg(1, 0, 0, 4, 32'h0);   // R3 odd ratio

    // R4 write without request
    write_cfg(mk(9, 9, 0, 0));
    chk(rdata == 32'h0099_0000, "R4 pending stored, no request", int'(rdata), 32'h0099_0000);
    measure(0, lo, hi);
    chk(lo == 2, "R4 low unchanged", lo, 2);
    chk(hi == 1, "R4 high unchanged", hi, 1);
    chk(rdata[25] == 1'b0, "R4 request stays clear", int'(rdata[25]), 0);

    // R6 bypass with counts present
    run_cfg(5, 2, 1, 8, 32'h0);
    check_bypass_levels("R6 bypass follows source");
    write_cfg(mk(0, 0, 0, 0));
    check_bypass_levels("R4 bypass kept without request");

    // R7 leave bypass
    run_cfg(1, 2, 0, 3, 32'h0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule